// File: doc/BRIEF.md
# Non-Maskable Interrupt Source Logic

This block turns two active-low error inputs into one non-maskable interrupt line for the processor. The two inputs are a system-error input and an I/O-channel-check input. Each input passes through a two-flop synchronizer. A falling edge on an input sets a sticky status bit for that source, but only if the source is enabled. The processor sees the interrupt on the rising edge of the output. The output stays high for as long as any pending source is enabled and the global mask is open.

Software uses two byte-wide registers, selected by a one-bit address:

- **Address 0 (control/status register).** It holds a disable bit for each source; a 0 in a disable bit enables that source. It also holds the two read-only status bits, so software can see which source fired. Writing 1 to a source's disable bit clears that source's status and removes its share of the output. Writing 0 to the bit enables the source again.
- **Address 1 (mask/clock address register).** It holds the global mask bit next to a seven-bit clock address field. The field is stored and read back but has no other effect.

Reads are combinational from the selected register. Writes take effect at the clock edge.

Top module: `nmi_src_ctl`

## Requirements
- R1: After reset, `nmi` is 0. Register 0 reads 8'h03 (both sources disabled, both status bits 0). Register 1 reads 8'h80 (mask set, clock address 0).
- R2: In register 0, bit 0 disables the system-error source (1 = disabled). Bit 7 is its status. With bit 0 at 0, a falling edge on `serr_n` sets bit 7 at the third rising clock edge after the input goes low.
- R3: In register 0, bit 1 disables the channel-check source. Bit 6 is its status. With bit 1 at 0, a falling edge on `iochk_n` sets bit 6 with the same three-edge latency.
- R4: `nmi` equals the OR of the two status bits, gated by register 1 bit 7 (1 = masked). It is combinational from the registers.
- R5: Writing 1 to a source's disable bit clears that source's status at that clock edge. While the disable bit is 1, edges on that source leave its status at 0.
- R6: A status bit stays set after its input returns high. It stays set until its disable bit is written to 1.
- R7: If a disable-setting write and a source edge fall in the same cycle, the write wins and the status stays 0. If a disable-clearing write and a source edge fall in the same cycle, the edge is captured.
- R8: Register 0 bits 7:6 are read-only, so writes to them are ignored. Bits 5:2 always read 0.
- R9: Register 1 bits 6:0 are stored and read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 = control/status, 1 = mask/clock address |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| serr_n | input | 1 | System-error input, active low, asynchronous |
| iochk_n | input | 1 | Channel-check input, active low, asynchronous |
| nmi | output | 1 | Non-maskable interrupt to the processor |

## Verification
Two functions can land in the same cycle: a software write to a disable bit, and a source edge reaching the status logic after the synchronizer delay. The bench provokes this collision by timing the write strobe to the third clock edge after it drives a source low. It does this once with a write that sets the disable bit and once with a write that clears it. The status read afterwards must show the write winning in the first case and the edge captured in the second. A sweep over every mask, disable and source combination then checks the status bits and the output against the values the bench computes.

// File: rtl/nmi_src_ctl.sv
module nmi_src_ctl #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          serr_n,
  input  logic          iochk_n,
  output logic          nmi
);
  localparam int AW = DW - 1;

  logic [SYNC_STAGES:0] serr_sy, iochk_sy;
  logic dis_serr, dis_iochk, st_serr, st_iochk, mask;
  logic [AW-1:0] caddr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      serr_sy  <= '1;
      iochk_sy <= '1;
    end else begin
      serr_sy  <= {serr_sy[SYNC_STAGES-1:0], serr_n};
      iochk_sy <= {iochk_sy[SYNC_STAGES-1:0], iochk_n};
    end

  wire fall_serr  = serr_sy[SYNC_STAGES]  & ~serr_sy[SYNC_STAGES-1];
  wire fall_iochk = iochk_sy[SYNC_STAGES] & ~iochk_sy[SYNC_STAGES-1];

  wire wr_ctl = wr_en & ~reg_sel;
  wire wr_msk = wr_en &  reg_sel;
  wire dis_serr_nx  = wr_ctl ? wdata[0] : dis_serr;
  wire dis_iochk_nx = wr_ctl ? wdata[1] : dis_iochk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dis_serr  <= 1'b1;
      dis_iochk <= 1'b1;
      st_serr   <= 1'b0;
      st_iochk  <= 1'b0;
      mask      <= 1'b1;
      caddr     <= '0;
    end else begin
      dis_serr  <= dis_serr_nx;
      dis_iochk <= dis_iochk_nx;
      st_serr   <= ~dis_serr_nx  & (st_serr  | fall_serr);
      st_iochk  <= ~dis_iochk_nx & (st_iochk | fall_iochk);
      if (wr_msk) {mask, caddr} <= wdata;
    end

  assign nmi   = ~mask & (st_serr | st_iochk);
  assign rdata = reg_sel ? {mask, caddr}
                         : {st_serr, st_iochk, {(DW-4){1'b0}}, dis_iochk, dis_serr};

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) mask |-> !nmi); // R4
  AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_serr) |-> $past(fall_serr)); // R2
  AST_IOCHK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_iochk) |-> $past(fall_iochk)); // R3
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (dis_serr && dis_iochk) |-> !nmi); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (st_serr && !(wr_ctl && wdata[0])) |=> st_serr); // R6
  AST_RO_STATUS: assert property (@(posedge clk) disable iff (!rst_n) (!st_iochk && !fall_iochk && wr_ctl && wdata[6]) |=> !st_iochk); // R8
endmodule

// File: tb/sim_nmi_src_ctl.sv
module sim_nmi_src_ctl;
  logic clk = 1'b0, rst_n = 1'b0, reg_sel = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00, rdata;
  logic serr_n = 1'b1, iochk_n = 1'b1, nmi;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  nmi_src_ctl u0 (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
                  .wdata(wdata), .rdata(rdata), .serr_n(serr_n), .iochk_n(iochk_n), .nmi(nmi));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_sel = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic a, input logic [7:0] exp);
    @(negedge clk); reg_sel = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(input logic s, input logic c);
    @(negedge clk); serr_n = ~s; iochk_n = ~c;
    repeat (4) @(negedge clk);
    serr_n = 1'b1; iochk_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 nmi", {7'b0, nmi}, 8'h00);
    rd("R1 ctrl", 1'b0, 8'h03);
    rd("R1 mask", 1'b1, 8'h80);

    // R2 latency: status appears at third rising edge
    wr(1'b1, 8'h00); wr(1'b0, 8'h02);
    @(negedge clk); reg_sel = 1'b0; serr_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R2 not yet", rdata, 8'h02);
    @(posedge clk); #1;
    chk("R2 set", rdata, 8'h82);
    chk("R4 nmi", {7'b0, nmi}, 8'h01);
    @(negedge clk); serr_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R6 sticky", 1'b0, 8'h82);
    wr(1'b0, 8'hC2);
    rd("R8 ro write", 1'b0, 8'h82);
    wr(1'b0, 8'h03);
    rd("R5 clear", 1'b0, 8'h03);
    chk("R5 nmi drop", {7'b0, nmi}, 8'h00);

    // R3 latency
    wr(1'b0, 8'h01);
    @(negedge clk); reg_sel = 1'b0; iochk_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R3 not yet", rdata, 8'h01);
    @(posedge clk); #1;
    chk("R3 set", rdata, 8'h41);
    @(negedge clk); iochk_n = 1'b1;
    wr(1'b0, 8'hFF);
    rd("R8 ro/zero bits", 1'b0, 8'h03);

    // R7 collision: disable-setting write with edge
    wr(1'b0, 8'h00);
    @(negedge clk); serr_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_sel = 1'b0; wdata = 8'h01; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; serr_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R7 set wins", 1'b0, 8'h01);
    // R7 collision: disable-clearing write with edge
    wr(1'b0, 8'h03);
    @(negedge clk); serr_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_sel = 1'b0; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; serr_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R7 edge captured", 1'b0, 8'h80);
    wr(1'b0, 8'h03);

    // R9 clock address storage sweep
    for (int v = 0; v < 256; v += 37) begin
      wr(1'b1, v[7:0]);
      rd("R9 readback", 1'b1, v[7:0]);
    end

    // R2 R3 R4 R5 sweep over mask, disables, sources
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 4; d++)
        for (int p = 0; p < 4; p++) begin
          logic [1:0] st;
          logic [7:0] exp;
          wr(1'b0, 8'h03);
          wr(1'b1, {m[0], 7'h15});
          wr(1'b0, {6'b0, d[1:0]});
          pulse(p[0], p[1]);
          st = {p[0] & ~d[0], p[1] & ~d[1]};
          exp = {st, 4'b0, d[1:0]};
          rd("R2 R3 R5 sweep status", 1'b0, exp);
          chk("R4 sweep nmi", {7'b0, nmi}, {7'b0, ~m[0] & (|st)});
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule